// File: doc/BRIEF.md
# DRAM Self-Refresh Sequencer

This block sits in a memory controller between the power manager and the command path of a DDR3-class SDRAM. When the power manager pulses a request to sleep, the sequencer waits until the memory can legally enter self refresh. That means every bank is idle, no data burst is running, and the precharge recovery time has run out. It then turns termination off, issues the refresh command together with a low clock-enable, and holds the memory clock for a programmed number of cycles. After that it may gate the clock off.

On a wake request it keeps clock-enable low until the programmed minimum low time has passed. It then restores the clock for a programmed lead time and raises clock-enable. It reports readiness in two steps: first for commands that do not depend on a locked DLL, later for all commands. All waits are cycle counts given on input ports, and each count must be at least 1. A configuration input tells the block that the clock stays running through self refresh. In that case the hold and lead waits are skipped and the clock enable never drops.

Top module: `dram_sref_seq`

## Requirements
- R1: While reset is asserted, cke and odt are 0, clk_en is 1, cmd is 2'b00 and the three status outputs are 0. This holds even if reset arrives during self refresh. In the first cycle after reset is released, cke and dll_cmd_ready are 1.
- R2: The refresh command (cmd 2'b10) is never issued while banks_idle is 0, while burst_active is 1, or before precharge recovery has run out. Suppose enter_req and a precharge_issued pulse arrive in the same cycle with the banks otherwise ready. The refresh then appears exactly rp_cyc+2 cycles later when term_enabled is 0, and rp_cyc+3 cycles later when it is 1.
- R3: odt follows odt_req while the block is idle or waiting to enter. From one cycle after the last waiting cycle until dll_cmd_ready returns, odt is 0. When term_enabled is 1, that extra cycle carries a NOP (cmd 2'b01) before the refresh.
- R4: In the cycle that cmd is 2'b10, cke is 0 and odt is 0.
- R5: cmd is 2'b01 (NOP) in every cycle after the refresh cycle up to the cycle before cmd_ready rises. Otherwise, outside the refresh and termination-off cycles, cmd is 2'b00 and the controller owns the bus.
- R6: With keep_clk_on at 0, clk_en falls exactly clk_hold_cyc+1 cycles after the refresh cycle. cke rises exactly clk_lead_cyc cycles after clk_en returns to 1.
- R7: With keep_clk_on at 1, clk_en never falls during the sequence.
- R8: cke stays low at least cke_low_cyc+1 cycles counting the refresh cycle. A wake request made earlier is held and acted on. With keep_clk_on at 1 and a wake pulse e cycles after the refresh cycle, cke rises max(e, cke_low_cyc)+1 cycles after it. With keep_clk_on at 0, it rises max(e, cke_low_cyc, clk_hold_cyc+1)+clk_lead_cyc+1 cycles after it.
- R9: cmd_ready rises exactly rdy_cyc+1 cycles after cke rises, and stays high until dll_cmd_ready rises.
- R10: When dll_rdy_cyc exceeds rdy_cyc, dll_cmd_ready rises exactly dll_rdy_cyc+1 cycles after cke rises.
- R11: enter_req has no effect during self refresh, and exit_req has no effect while idle.
- R12: At most one of in_self_refresh, cmd_ready and dll_cmd_ready is high at a time. in_self_refresh is high from the refresh cycle until cmd_ready rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enter_req | input | 1 | Pulse: begin self refresh entry |
| exit_req | input | 1 | Pulse: begin self refresh exit |
| banks_idle | input | 1 | All banks precharged and idle |
| burst_active | input | 1 | A data burst is in flight |
| precharge_issued | input | 1 | A precharge went out this cycle; restarts recovery count |
| term_enabled | input | 1 | Nominal or write termination enabled in mode setup |
| keep_clk_on | input | 1 | Clock is left running through self refresh |
| odt_req | input | 1 | Termination value wanted by the controller |
| rp_cyc | input | CNT_W | Precharge recovery cycles |
| clk_hold_cyc | input | CNT_W | Clock hold cycles after entry |
| clk_lead_cyc | input | CNT_W | Clock valid cycles before exit |
| cke_low_cyc | input | CNT_W | Minimum clock-enable low cycles |
| rdy_cyc | input | CNT_W | Exit wait before non-DLL commands |
| dll_rdy_cyc | input | CNT_W | Exit wait before DLL-dependent commands |
| cke | output | 1 | Memory clock enable |
| cmd | output | 2 | 00 controller owns bus, 01 NOP, 10 REFRESH |
| odt | output | 1 | Memory on-die termination |
| clk_en | output | 1 | Memory clock gate enable |
| in_self_refresh | output | 1 | Sequence in progress, memory asleep or waking |
| cmd_ready | output | 1 | Commands not needing a locked DLL allowed |
| dll_cmd_ready | output | 1 | All commands allowed |

## Verification
The checker assumes that term_enabled, keep_clk_on and all six counts stay fixed from an entry request until dll_cmd_ready returns, and that every count is at least 1. It also assumes that banks_idle and burst_active do not change between the last waiting cycle and the refresh. The bench changes configuration only while the block is idle and dll_cmd_ready is high. It uses dll_rdy_cyc values larger than rdy_cyc, and it changes bank and burst inputs only while the block is still waiting to enter. Wake pulses are placed both before and after the minimum low time, so the held-request path and the direct path both occur.

// File: rtl/sref_pkg.sv
package sref_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_WAIT_PRE,
      S_ODT_OFF,
      S_ENTER,
      S_HOLD_CLK,
      S_SELF_REF,
      S_CLK_RESTORE,
      S_EXIT,
      S_WAIT_XS,
      S_WAIT_XSDLL
   } sref_state_e;

   localparam logic [1:0] CMD_PASS = 2'b00;
   localparam logic [1:0] CMD_NOP  = 2'b01;
   localparam logic [1:0] CMD_REF  = 2'b10;

endpackage

// File: rtl/sref_downcnt.sv
// Loadable down counter that parks at zero.
module sref_downcnt #(
   parameter int unsigned W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         zero
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/sref_out_dec.sv
// Moore decode of the sequencer state onto the memory-side pins.
module sref_out_dec
   import sref_pkg::*;
(
   input  sref_state_e state,
   input  logic        live,
   input  logic        odt_req,
   input  logic        keep_clk_on,
   output logic        cke,
   output logic [1:0]  cmd,
   output logic        odt,
   output logic        clk_en,
   output logic        in_sr,
   output logic        cmd_rdy,
   output logic        dll_rdy
);
   logic low_state;
   logic open_state;

   assign low_state  = (state == S_ENTER) || (state == S_HOLD_CLK) ||
                       (state == S_SELF_REF) || (state == S_CLK_RESTORE);
   assign open_state = (state == S_IDLE) || (state == S_WAIT_PRE);

   assign cke     = live && !low_state;
   assign odt     = live && open_state && odt_req;
   assign clk_en  = !((state == S_SELF_REF) && !keep_clk_on);
   assign cmd_rdy = (state == S_WAIT_XSDLL);
   assign dll_rdy = live && (state == S_IDLE);
   assign in_sr   = !open_state && (state != S_ODT_OFF) && (state != S_WAIT_XSDLL);

   always_comb begin
      unique case (state)
         S_IDLE, S_WAIT_PRE, S_WAIT_XSDLL: cmd = CMD_PASS;
         S_ENTER:                          cmd = CMD_REF;
         default:                          cmd = CMD_NOP;
      endcase
   end
endmodule

// File: rtl/dram_sref_seq.sv
module dram_sref_seq
   import sref_pkg::*;
#(
   parameter int unsigned CNT_W            = 10,
   parameter bit          ODT_GUARD_ALWAYS = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enter_req,
   input  logic             exit_req,
   input  logic             banks_idle,
   input  logic             burst_active,
   input  logic             precharge_issued,
   input  logic             term_enabled,
   input  logic             keep_clk_on,
   input  logic             odt_req,
   input  logic [CNT_W-1:0] rp_cyc,
   input  logic [CNT_W-1:0] clk_hold_cyc,
   input  logic [CNT_W-1:0] clk_lead_cyc,
   input  logic [CNT_W-1:0] cke_low_cyc,
   input  logic [CNT_W-1:0] rdy_cyc,
   input  logic [CNT_W-1:0] dll_rdy_cyc,
   output logic             cke,
   output logic [1:0]       cmd,
   output logic             odt,
   output logic             clk_en,
   output logic             in_self_refresh,
   output logic             cmd_ready,
   output logic             dll_cmd_ready
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2 || CNT_W > 24) begin : g_bad_width
      $error("dram_sref_seq: CNT_W must lie in 2..24");
   end

   sref_state_e      state_q, state_d;
   logic             live_q;
   logic             pend_exit_q;
   logic             take_odt;
   logic             main_load, main_zero;
   logic [CNT_W-1:0] main_val;
   logic             aux_load, aux_zero;
   logic [CNT_W-1:0] aux_val;
   logic             rp_zero;
   logic             wake_go;

   // Variant: optional termination-off cycle before entry.
   if (ODT_GUARD_ALWAYS) begin : g_odt_always
      assign take_odt = 1'b1;
   end else begin : g_odt_cfg
      assign take_odt = term_enabled;
   end

   assign wake_go = (exit_req || pend_exit_q) && aux_zero;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         S_IDLE:        if (live_q && enter_req) state_d = S_WAIT_PRE;
         S_WAIT_PRE:    if (banks_idle && !burst_active && rp_zero)
                           state_d = take_odt ? S_ODT_OFF : S_ENTER;
         S_ODT_OFF:     state_d = S_ENTER;
         S_ENTER:       state_d = keep_clk_on ? S_SELF_REF : S_HOLD_CLK;
         S_HOLD_CLK:    if (main_zero) state_d = S_SELF_REF;
         S_SELF_REF:    if (wake_go) state_d = keep_clk_on ? S_EXIT : S_CLK_RESTORE;
         S_CLK_RESTORE: if (main_zero) state_d = S_EXIT;
         S_EXIT:        state_d = S_WAIT_XS;
         S_WAIT_XS:     if (main_zero) state_d = S_WAIT_XSDLL;
         S_WAIT_XSDLL:  if (aux_zero) state_d = S_IDLE;
         default:       state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= S_IDLE;
         live_q      <= 1'b0;
         pend_exit_q <= 1'b0;
      end else begin
         state_q <= state_d;
         live_q  <= 1'b1;
         if (state_q == S_SELF_REF && state_d != S_SELF_REF)
            pend_exit_q <= 1'b0;
         else if (exit_req && (state_q == S_ENTER || state_q == S_HOLD_CLK ||
                               state_q == S_SELF_REF))
            pend_exit_q <= 1'b1;
      end
   end

   // Per-state window timer: a timed state lasts exactly its count.
   assign main_load = (state_d != state_q);
   always_comb begin
      unique case (state_d)
         S_HOLD_CLK:    main_val = clk_hold_cyc - ONE;
         S_CLK_RESTORE: main_val = clk_lead_cyc - ONE;
         S_WAIT_XS:     main_val = rdy_cyc - ONE;
         default:       main_val = '0;
      endcase
   end

   // Long-window timer: low-time minimum after entry, DLL wait after exit.
   assign aux_load = (state_q == S_ENTER) || (state_q == S_EXIT);
   assign aux_val  = (state_q == S_ENTER) ? (cke_low_cyc - ONE) : (dll_rdy_cyc - ONE);

   sref_downcnt #(.W(CNT_W)) main_tmr_i (
      .clk(clk), .rst_n(rst_n), .load(main_load), .load_val(main_val), .zero(main_zero));

   sref_downcnt #(.W(CNT_W)) aux_tmr_i (
      .clk(clk), .rst_n(rst_n), .load(aux_load), .load_val(aux_val), .zero(aux_zero));

   sref_downcnt #(.W(CNT_W)) rp_tmr_i (
      .clk(clk), .rst_n(rst_n), .load(precharge_issued), .load_val(rp_cyc), .zero(rp_zero));

   sref_out_dec out_dec_i (
      .state(state_q), .live(live_q), .odt_req(odt_req), .keep_clk_on(keep_clk_on),
      .cke(cke), .cmd(cmd), .odt(odt), .clk_en(clk_en), .in_sr(in_self_refresh),
      .cmd_rdy(cmd_ready), .dll_rdy(dll_cmd_ready));
endmodule

// File: rtl/sref_seq_chk.sv
module sref_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cke,
   input logic [1:0] cmd,
   input logic       odt,
   input logic       clk_en,
   input logic       in_self_refresh,
   input logic       cmd_ready,
   input logic       dll_cmd_ready
);
   p_ref_cke_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b10) |-> (!cke && !odt));

   p_nop_after_ref_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == 2'b10) |=> (cmd == 2'b01));

   p_status_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({in_self_refresh, cmd_ready, dll_cmd_ready}));

   p_clk_with_cke_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cke |-> clk_en);

   p_clk_before_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cke) && in_self_refresh) |-> $past(clk_en));

   p_ready_needs_cke_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |-> cke);

   p_dll_follows_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_ready) |-> dll_cmd_ready);
endmodule

bind dram_sref_seq sref_seq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .odt(odt), .clk_en(clk_en),
   .in_self_refresh(in_self_refresh), .cmd_ready(cmd_ready), .dll_cmd_ready(dll_cmd_ready));

// File: tb/dram_sref_seq_tb_top.sv
module dram_sref_seq_tb_top;
   localparam int W = 10;

   typedef struct packed {
      logic         term;
      logic         keep;
      logic [W-1:0] rp, hold, lead, low, xs, xsdll, e;
   } row_t;

   localparam row_t ROWS [0:4] = '{
      '{1'b1, 1'b0, 10'd3, 10'd2,  10'd3, 10'd4, 10'd5,  10'd9,  10'd1},
      '{1'b0, 1'b0, 10'd1, 10'd1,  10'd1, 10'd1, 10'd1,  10'd2,  10'd8},
      '{1'b1, 1'b1, 10'd5, 10'd3,  10'd3, 10'd6, 10'd2,  10'd7,  10'd0},
      '{1'b0, 1'b1, 10'd2, 10'd2,  10'd2, 10'd1, 10'd3,  10'd4,  10'd5},
      '{1'b1, 1'b0, 10'd7, 10'd10, 10'd6, 10'd3, 10'd12, 10'd30, 10'd2}
   };

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic rst_n = 1'b0, enter_req = 1'b0, exit_req = 1'b0, banks_idle = 1'b1;
   logic burst_active = 1'b0, precharge_issued = 1'b0, term_enabled = 1'b0;
   logic keep_clk_on = 1'b0, odt_req = 1'b1;
   logic [W-1:0] rp_cyc = 1, clk_hold_cyc = 1, clk_lead_cyc = 1, cke_low_cyc = 1;
   logic [W-1:0] rdy_cyc = 1, dll_rdy_cyc = 2;
   logic cke, odt, clk_en, in_self_refresh, cmd_ready, dll_cmd_ready;
   logic [1:0] cmd;

   dram_sref_seq #(.CNT_W(W)) dut_i (.*);

   int total = 0, bad = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int max3(input int a, input int b, input int c);
      int m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

   task automatic run_row(input row_t r);
      int kref = -1, koff = -1, kon = -1, krise = -1, krdy = -1, kdll = -1;
      int nop_bad = 0, sr_bad = 0, odt_bad = 0, cke_at_ref = 1, odt_at_ref = 1;
      int exp_rise, exp_ref;
      term_enabled = r.term; keep_clk_on = r.keep; rp_cyc = r.rp;
      clk_hold_cyc = r.hold; clk_lead_cyc = r.lead; cke_low_cyc = r.low;
      rdy_cyc = r.xs; dll_rdy_cyc = r.xsdll; odt_req = 1'b1;
      enter_req = 1'b1; precharge_issued = 1'b1;
      @(negedge clk);
      enter_req = 1'b0; precharge_issued = 1'b0;
      for (int k = 1; k < 400 && kdll < 0; k++) begin
         exit_req = 1'b0;
         if (kref < 0 && cmd == 2'b10) begin
            kref = k; cke_at_ref = cke; odt_at_ref = odt;
         end
         if (kref >= 0 && koff < 0 && !clk_en) koff = k;
         if (koff >= 0 && kon < 0 && clk_en) kon = k;
         if (kref >= 0 && krise < 0 && cke) krise = k;
         if (krdy < 0 && cmd_ready) krdy = k;
         if (kref >= 0 && kdll < 0 && dll_cmd_ready) kdll = k;
         if (kref >= 0 && k > kref && krdy < 0 && cmd != 2'b01) nop_bad++;
         if (in_self_refresh != (kref >= 0 && krdy < 0)) sr_bad++;
         if (!$onehot0({in_self_refresh, cmd_ready, dll_cmd_ready})) sr_bad++;
         if (odt != ((kref < 0 && k <= int'(r.rp) + 1) || kdll >= 0)) odt_bad++;
         if (kref >= 0 && k == kref + int'(r.e)) exit_req = 1'b1;
         @(negedge clk);
      end
      exit_req = 1'b0;
      exp_ref = int'(r.rp) + 2 + (r.term ? 1 : 0);
      chk(kref == exp_ref, "R2 entry latency", kref, exp_ref);
      chk(cke_at_ref == 0 && odt_at_ref == 0, "R4 cke/odt at refresh", cke_at_ref + odt_at_ref, 0);
      chk(odt_bad == 0, "R3 odt tracking", odt_bad, 0);
      chk(nop_bad == 0, "R5 NOP span", nop_bad, 0);
      chk(sr_bad == 0, "R12 status window", sr_bad, 0);
      if (r.keep) begin
         chk(koff < 0, "R7 clock never gated", koff, -1);
         exp_rise = max3(int'(r.e), int'(r.low), 0) + 1;
      end else begin
         chk(koff - kref == int'(r.hold) + 1, "R6 clock hold", koff - kref, int'(r.hold) + 1);
         chk(krise - kon == int'(r.lead), "R6 clock lead", krise - kon, int'(r.lead));
         exp_rise = max3(int'(r.e), int'(r.low), int'(r.hold) + 1) + int'(r.lead) + 1;
      end
      chk(krise - kref == exp_rise, "R8 exit timing", krise - kref, exp_rise);
      chk(krdy - krise == int'(r.xs) + 1, "R9 cmd_ready delay", krdy - krise, int'(r.xs) + 1);
      chk(kdll - krise == int'(r.xsdll) + 1, "R10 dll ready delay", kdll - krise, int'(r.xsdll) + 1);
   endtask

   task automatic wait_ref(output int n);
      n = -1;
      for (int k = 0; k < 200 && n < 0; k++) begin
         if (cmd == 2'b10) n = k;
         else @(negedge clk);
      end
   endtask

   task automatic finish_exit();
      int got = 0;
      exit_req = 1'b1;
      @(negedge clk);
      exit_req = 1'b0;
      for (int k = 0; k < 400 && got == 0; k++) begin
         if (dll_cmd_ready) got = 1;
         else @(negedge clk);
      end
      chk(got == 1, "R10 return to ready", got, 1);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int n, viol;
      // R1: reset values
      repeat (3) @(negedge clk);
      chk(cke == 0 && odt == 0 && clk_en == 1 && cmd == 2'b00, "R1 reset pins",
          {cke, odt, clk_en, cmd}, 5'b00100);
      chk(!in_self_refresh && !cmd_ready && !dll_cmd_ready, "R1 reset status",
          {in_self_refresh, cmd_ready, dll_cmd_ready}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cke == 1 && dll_cmd_ready == 1, "R1 after release", {cke, dll_cmd_ready}, 3);

      // R3: odt follows request while idle
      odt_req = 1'b0; #1;
      chk(odt == 0, "R3 idle odt low", odt, 0);
      odt_req = 1'b1; #1;
      chk(odt == 1, "R3 idle odt high", odt, 1);
      @(negedge clk);

      // table walk
      for (int i = 0; i < 5; i++) run_row(ROWS[i]);

      // R2: gating by bank state and burst
      term_enabled = 0; keep_clk_on = 0; rp_cyc = 2; clk_hold_cyc = 2; clk_lead_cyc = 2;
      cke_low_cyc = 2; rdy_cyc = 2; dll_rdy_cyc = 4;
      banks_idle = 0; enter_req = 1; @(negedge clk); enter_req = 0;
      viol = 0;
      repeat (15) begin
         if (cmd != 2'b00 || in_self_refresh) viol++;
         @(negedge clk);
      end
      banks_idle = 1; burst_active = 1;
      repeat (15) begin
         if (cmd != 2'b00 || in_self_refresh) viol++;
         @(negedge clk);
      end
      chk(viol == 0, "R2 held while busy", viol, 0);
      burst_active = 0;
      @(negedge clk);
      chk(cmd == 2'b10, "R2 refresh once free", cmd, 2);
      finish_exit();

      // R11: enter_req ignored in self refresh
      enter_req = 1; @(negedge clk); enter_req = 0;
      wait_ref(n);
      repeat (6) @(negedge clk);
      enter_req = 1; @(negedge clk); enter_req = 0;
      chk(in_self_refresh && cmd == 2'b01 && !clk_en, "R11 enter ignored asleep",
          {in_self_refresh, cmd, clk_en}, 4'b1010);
      finish_exit();

      // R11: exit_req ignored in idle
      exit_req = 1; @(negedge clk); exit_req = 0;
      viol = 0;
      repeat (10) begin
         if (!cke || !dll_cmd_ready || cmd != 2'b00) viol++;
         @(negedge clk);
      end
      chk(viol == 0, "R11 exit ignored idle", viol, 0);

      // R1: reset during self refresh
      enter_req = 1; @(negedge clk); enter_req = 0;
      wait_ref(n);
      repeat (5) @(negedge clk);
      chk(!clk_en, "R6 clock gated before reset", clk_en, 0);
      rst_n = 0; #1;
      chk(cke == 0 && clk_en == 1 && odt == 0 && !in_self_refresh, "R1 reset while asleep",
          {cke, clk_en, odt, in_self_refresh}, 4'b0100);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(cke == 1 && dll_cmd_ready == 1, "R1 recovered", {cke, dll_cmd_ready}, 3);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule